// File: doc/BRIEF.md
# Dithered Phase-Accumulator Clock Generator

The block is a numerically controlled oscillator for clock synthesis. A 32-bit phase register is advanced on every clock by a tuning word, and its most significant bit is the synthesized clock. The average output frequency is tune_word × fclk / 2^32. At a 100 MHz system clock this gives a frequency step of roughly 0.023 Hz. Software can rewrite the tuning word at any time, and the new value is captured on the next clock.

A plain accumulator places every output edge on a system clock edge. The timing error this causes repeats with a fixed pattern, so it shows up as discrete spurs in the output spectrum. When dither is enabled, a 4-bit pseudo-random value is added to the phase before the MSB is taken. That value is never written back into the phase register. Edges therefore move by up to one system clock, which breaks up the repeating pattern. The noise floor rises, but the average frequency is exactly the same as without dither. Each of the four dither bits comes from its own 30-bit maximal-length LFSR, so the dither sequence takes a very long time to repeat.

Top module: `dither_nco`

## Requirements
- R1: While rst_n is low, the registered tuning word, the phase register and clk_out are all cleared to 0, and each LFSR is loaded with its own distinct non-zero seed.
- R2: tune_word is registered on each rising clock edge. A value sampled at edge k is added to the phase at edge k+1 and first affects clk_out at edge k+2.
- R3: On every clock the phase register advances by the registered tuning word, modulo 2^32. Over a long run, the number of rising edges of clk_out matches tune_word × cycles / 2^32 to within one edge.
- R4: With dither_en low, clk_out after an edge equals bit 31 of the phase register as it stood before that edge.
- R5: With dither_en high, clk_out after an edge equals bit 31 of (phase + d) mod 2^32, where d in 0..15 is the dither word and bit i of d is supplied by LFSR i. The dither never changes the phase register, so the long-run rising-edge count stays within one edge of the undithered count.
- R6: Each LFSR is 30 bits wide and uses the maximal-length feedback x^30 + x^6 + x^4 + x + 1, so it never reaches the all-zero state. All four dither bits therefore keep changing.
- R7: With the phase held at a fixed value P, the fraction of cycles in which clk_out is 1 follows the dither distribution. For P = 2^31 − 1 it is above 80% but not 100%. For P = 2^31 − 8 it is between 30% and 70%. For P = 2^31 − 15 it is above 0% and at most 20%.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; all state changes on the rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| tune_word | input | 32 | Phase increment per clock, as a fraction of 2^32 |
| dither_en | input | 1 | Enables the pseudo-random addition on the output path |
| clk_out | output | 1 | Synthesized clock (registered) |

## Verification
Two register stages separate a tuning-word change from its effect on clk_out. The phase register updates one edge after the word is captured, and clk_out one edge after that. The bench keeps a cycle-accurate arithmetic model of the registered word, the phase and the undithered MSB, updated on the same rising edges. It compares clk_out with that model at the falling edge that follows, so each result is read half a period after it is due. With dither off the comparison is exact on every cycle. With dither on, clk_out must equal the MSB of either phase or phase + 15 in that same cycle. The edge-count and duty-fraction checks are made only after windows thousands of cycles long.

// File: rtl/dither_nco.sv
module dither_nco #(
  parameter int ACC_W  = 32,
  parameter int DITH_W = 4,
  parameter int LFSR_W = 30
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ACC_W-1:0] tune_word,
  input  logic             dither_en,
  output logic             clk_out
);

  localparam int DMAX = (1 << DITH_W) - 1;

  logic [ACC_W-1:0]  tune_q;
  logic [ACC_W-1:0]  acc;
  logic [DITH_W-1:0] dith;
  logic              pv;

  wire [ACC_W-1:0] dsum = acc + ACC_W'(dither_en ? dith : '0);
  wire [ACC_W-1:0] acc_top = acc + ACC_W'(DMAX);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tune_q  <= '0;
      acc     <= '0;
      clk_out <= 1'b0;
      pv      <= 1'b0;
    end else begin
      tune_q  <= tune_word;
      acc     <= acc + tune_q;
      clk_out <= dsum[ACC_W-1];
      pv      <= 1'b1;
    end
  end

  for (genvar g = 0; g < DITH_W; g++) begin : g_lfsr
    localparam logic [LFSR_W-1:0] SEED =
      LFSR_W'(32'h0000_ACE1 + 32'(g) * 32'h0135_79BD) | LFSR_W'(1);
    logic [LFSR_W-1:0] s;

    always_ff @(posedge clk) begin
      if (!rst_n) s <= SEED;
      else        s <= {s[LFSR_W-2:0], s[LFSR_W-1] ^ s[5] ^ s[3] ^ s[0]};
    end

    assign dith[g] = s[LFSR_W-1];

    a_r6_lfsr_alive: assert property (@(posedge clk) disable iff (!rst_n)
      s != '0);
  end

  a_r1_reset_clear: assert property (@(posedge clk)
    $past(!rst_n) |-> (clk_out == 1'b0 && acc == '0));

  a_r2_tune_capture: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> tune_q == $past(tune_word));

  a_r3_phase_step: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> acc == $past(acc) + $past(tune_q));

  a_r4_plain_msb: assert property (@(posedge clk) disable iff (!rst_n)
    (pv && $past(!dither_en)) |-> clk_out == $past(acc[ACC_W-1]));

  a_r5_dither_band: assert property (@(posedge clk) disable iff (!rst_n)
    pv |-> (clk_out == $past(acc[ACC_W-1]) || clk_out == $past(acc_top[ACC_W-1])));

endmodule

// File: tb/dither_nco_tb.sv
module dither_nco_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [31:0] tune_word = '0;
  logic        dither_en = 1'b0;
  logic        clk_out;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  dither_nco u_dut (.clk(clk), .rst_n(rst_n), .tune_word(tune_word),
                    .dither_en(dither_en), .clk_out(clk_out));

  always #10 clk = ~clk;

  logic [31:0] m_tq, m_acc;
  logic        m_out, m_hi;
  wire  [31:0] m_top = m_acc + 32'd15;

  always @(posedge clk) begin
    if (!rst_n) begin
      m_tq <= '0; m_acc <= '0; m_out <= 1'b0; m_hi <= 1'b0;
    end else begin
      m_tq  <= tune_word;
      m_acc <= m_acc + m_tq;
      m_out <= m_acc[31];
      m_hi  <= m_top[31];
    end
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0; tune_word = '0;
    repeat (3) @(negedge clk);
    check(clk_out == 1'b0, "R1 reset output", clk_out, 0);
    rst_n = 1'b1;
  endtask

  task automatic run(input int n, input bit dith, output int rises);
    bit prev = clk_out;
    rises = 0;
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      if (!dith)
        check(clk_out == m_out, "R4 plain msb", clk_out, m_out);
      else
        check(clk_out == m_out || clk_out == m_hi, "R5 dither band", clk_out, m_out);
      if (clk_out && !prev) rises++;
      prev = clk_out;
    end
  endtask

  task automatic freeze(input logic [31:0] p, input int lo_pct, input int hi_pct, input string tag);
    int ones = 0;
    int r;
    dither_en = 1'b1;
    do_reset();
    tune_word = p;
    @(negedge clk); tune_word = '0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < 2000; i++) begin
      @(negedge clk);
      check(clk_out == m_out || clk_out == m_hi, "R5 band frozen", clk_out, m_out);
      if (clk_out) ones++;
    end
    check(ones * 100 > lo_pct * 2000 && ones * 100 <= hi_pct * 2000 && ones < 2000,
          tag, ones, lo_pct * 20);
    dither_en = 1'b0;
    run(50, 0, r);
  endtask

  initial begin
    int r_plain, r_dith;
    longint exp_r;
    do_reset();

    // R2: tuning-word latency of two edges to clk_out
    tune_word = 32'h8000_0000;
    @(posedge clk); @(posedge clk); @(negedge clk);
    check(clk_out == 1'b0, "R2 latency early", clk_out, 0);
    @(negedge clk);
    check(clk_out == 1'b1, "R2 latency due", clk_out, 1);

    // R3/R4: exact undithered tracking and edge count
    do_reset();
    tune_word = 32'h0400_0000;
    run(6400, 0, r_plain);
    check(r_plain >= 99 && r_plain <= 101, "R3 edge count plain", r_plain, 100);

    tune_word = 32'h0123_4567;
    run(8000, 0, r_plain);
    exp_r = (64'h0123_4567 * 8000) >> 32;
    check(r_plain >= exp_r - 1 && r_plain <= exp_r + 1, "R3 edge count odd word", r_plain, exp_r);

    // R5: dithered edges keep the average rate
    do_reset();
    dither_en = 1'b1;
    tune_word = 32'h0400_0000;
    run(6400, 1, r_dith);
    check(r_dith >= 99 && r_dith <= 101, "R5 edge count dithered", r_dith, 100);
    tune_word = 32'h0123_4567;
    run(8000, 1, r_dith);
    check(r_dith >= exp_r - 1 && r_dith <= exp_r + 1, "R5 edge count odd dithered", r_dith, exp_r);

    // R6/R7: dither distribution with a frozen phase
    freeze(32'h7FFF_FFFF, 80, 100, "R7 ones fraction near top R6");
    freeze(32'h7FFF_FFF8, 30, 70, "R7 ones fraction middle R6");
    freeze(32'h7FFF_FFF1, 0, 20, "R7 ones fraction all bits set R6");

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end
endmodule